// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block derives the horizontal and vertical timing of a 525-line, two-field interlaced raster from a pixel-rate clock. It counts pixels along each line and lines across a frame. From those two counters it decodes an active-low horizontal sync, an active-low vertical sync, a field parity flag and an active-display enable. The frame is split into two fields of 262.5 lines each. The second field begins in the middle of a scan line, which gives the half-line offset that makes the raster interlace.

The visible picture is a band of 192 lines centred in each field. Every stored picture line is shown once in each field, so a downstream pixel fetch can use the active-line index directly, without regard to parity. Besides the vertical sync level, the block emits a single-clock marker at the leading edge of each vertical sync. Polling logic or a latency timer can lock onto that marker to learn where the beam is. All outputs are registered and trail the internal counters by one clock. Line totals, sync widths and porch lengths are parameters.

Top module: `raster_timing_gen`

## Requirements
- R1: `pixel_o` counts 0 to H_TOTAL-1 and then returns to 0. `line_o` advances by one when the pixel count wraps, and returns from FRAME_LINES-1 (524) to 0.
- R2: `hsync_n_o` is low for exactly H_SYNC clocks on every line. The low pulse starts at pixel H_ACTIVE+H_FRONT.
- R3: Each frame holds two fields of 262.5 lines, so `vsync_start_o` pulses every FRAME_LINES*H_TOTAL/2 clocks. The first field starts at pixel 0 of line 0. The second field starts at pixel H_TOTAL/2 of line 262.
- R4: `vsync_n_o` is low for exactly V_SYNC_LINES*H_TOTAL clocks, starting in the clock of `vsync_start_o`.
- R5: `vsync_start_o` is high for exactly one clock per field, and that clock is the first clock in which `vsync_n_o` is low.
- R6: `field_o` is 0 during the field that starts at line 0 and 1 during the field that starts mid-line 262. It changes only in a clock where `vsync_start_o` is high, so it alternates at every vertical sync.
- R7: The active window covers 192 whole lines per field: lines 35..226 in field 0 and lines 298..489 in field 1. The start of each band is (262-192)/2 lines after the first whole line of its field. `de_o` is high on pixels 0..H_ACTIVE-1 of those lines and low everywhere else, including during vertical sync. Each field therefore holds 192*H_ACTIVE enabled clocks.
- R8: `act_line_o` gives the index 0..191 of the active line, with the same index sequence in both fields. It is 0 outside the window.
- R9: While `rst_ni` is low, the outputs are idle: `hsync_n_o`=1, `vsync_n_o`=1, `vsync_start_o`=0, `field_o`=0, `de_o`=0, and `pixel_o`, `line_o` and `act_line_o` all 0. The first rising edge after release presents pixel 0 of line 0, with `vsync_start_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| vsync_start_o | output | 1 | One-clock marker at the vertical sync leading edge |
| field_o | output | 1 | Field parity, 0 = field starting at line 0 |
| de_o | output | 1 | Active display enable |
| pixel_o | output | $clog2(H_TOTAL+1) | Pixel position within the line |
| line_o | output | $clog2(FRAME_LINES+1) | Line position within the frame, 0..524 |
| act_line_o | output | $clog2(ACT_LINES) | Index of the active line, 0..191 |

## Verification
The bound checker enforces the local, cycle-to-cycle rules on every clock: the pixel count steps by one, the line number changes only at pixel 0, and the sync pulse starts at its pixel. It also enforces that `vsync_start_o` is a lone pulse sitting on the falling edge of vertical sync, that parity changes only with that pulse, and that `de_o` stays inside the horizontal window and outside vertical sync. Some properties span whole fields and frames, and only the bench's run over several frames can show them. These are the 262.5-line spacing between vertical syncs, the half-line offset of the second field's start, the length of the vertical sync, and the count of 192 active lines with their first line number and index range in each field. The same run confirms the recovery from a reset applied mid-frame.

// File: rtl/raster_pkg.sv
package raster_pkg;

  typedef struct packed {
    logic hsync_n;
    logic vsync_n;
    logic vsync_start;
    logic field;
    logic de;
  } raster_flags_t;

  localparam raster_flags_t FLAGS_IDLE = '{
    hsync_n: 1'b1, vsync_n: 1'b1, vsync_start: 1'b0, field: 1'b0, de: 1'b0
  };

endpackage

// File: rtl/raster_h_counter.sv
module raster_h_counter #(
  parameter int H_TOTAL = 910,
  localparam int HW = $clog2(H_TOTAL + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] h_o,
  output logic          wrap_o
);

  localparam logic [HW-1:0] LAST_C = HW'(H_TOTAL - 1);

  assign wrap_o = (h_o == LAST_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     h_o <= '0;
    else if (wrap_o) h_o <= '0;
    else             h_o <= h_o + 1'b1;
  end

endmodule

// File: rtl/raster_v_counter.sv
module raster_v_counter #(
  parameter int FRAME_LINES = 525,
  localparam int LW = $clog2(FRAME_LINES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [LW-1:0] ln_o
);

  localparam logic [LW-1:0] LAST_C = LW'(FRAME_LINES - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ln_o <= '0;
    else if (adv_i) begin
      if (ln_o == LAST_C) ln_o <= '0;
      else                ln_o <= ln_o + 1'b1;
    end
  end

endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int H_TOTAL      = 910,
  parameter int H_ACTIVE     = 640,
  parameter int H_FRONT      = 16,
  parameter int H_SYNC       = 68,
  parameter int V_SYNC_LINES = 3,
  parameter int FRAME_LINES  = 525,
  parameter int ACT_LINES    = 192,
  localparam int HW = $clog2(H_TOTAL + 1),
  localparam int LW = $clog2(FRAME_LINES + 1),
  localparam int AW = $clog2(ACT_LINES)
) (
  input  logic [HW-1:0] h_i,
  input  logic [LW-1:0] ln_i,
  output raster_flags_t flags_o,
  output logic [AW-1:0] act_line_o
);

  localparam int FIELD_WHOLE = (FRAME_LINES - 1) / 2;
  localparam int ACT_OFS     = (FIELD_WHOLE - ACT_LINES) / 2;

  localparam logic [HW-1:0] HALF_C   = HW'(H_TOTAL / 2);
  localparam logic [HW-1:0] HACT_C   = HW'(H_ACTIVE);
  localparam logic [HW-1:0] HS_BEG_C = HW'(H_ACTIVE + H_FRONT);
  localparam logic [HW-1:0] HS_END_C = HW'(H_ACTIVE + H_FRONT + H_SYNC);
  localparam logic [LW:0]   FL_C     = (LW+1)'(FRAME_LINES);
  localparam logic [LW:0]   VS2_C    = (LW+1)'(2 * V_SYNC_LINES);
  localparam logic [LW-1:0] MID_C    = LW'(FIELD_WHOLE);

  // position in half-line units, then relative to the current field start
  logic [LW:0] hl, hl_f;
  logic        second;

  assign hl     = {ln_i, 1'b0} | {{LW{1'b0}}, (h_i >= HALF_C)};
  assign second = (hl >= FL_C);
  assign hl_f   = second ? (hl - FL_C) : hl;

  logic [1:0]    in_win;
  logic [LW-1:0] rel [2];

  for (genvar f = 0; f < 2; f++) begin : g_field_win
    localparam logic [LW-1:0] BASE_C = LW'(f * (FIELD_WHOLE + 1) + ACT_OFS);
    localparam logic [LW-1:0] LIM_C  = LW'(f * (FIELD_WHOLE + 1) + ACT_OFS + ACT_LINES);
    assign in_win[f] = (ln_i >= BASE_C) && (ln_i < LIM_C);
    assign rel[f]    = ln_i - BASE_C;
  end

  logic act;
  assign act = in_win[second];

  always_comb begin
    flags_o.hsync_n     = !((h_i >= HS_BEG_C) && (h_i < HS_END_C));
    flags_o.vsync_n     = !(hl_f < VS2_C);
    flags_o.vsync_start = ((h_i == '0) && (ln_i == '0)) ||
                          ((h_i == HALF_C) && (ln_i == MID_C));
    flags_o.field       = second;
    flags_o.de          = act && (h_i < HACT_C);
    act_line_o          = act ? AW'(rel[second]) : '0;
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int H_TOTAL      = 910,
  parameter int H_ACTIVE     = 640,
  parameter int H_FRONT      = 16,
  parameter int H_SYNC       = 68,
  parameter int V_SYNC_LINES = 3,
  parameter int FRAME_LINES  = 525,
  parameter int ACT_LINES    = 192,
  localparam int HW = $clog2(H_TOTAL + 1),
  localparam int LW = $clog2(FRAME_LINES + 1),
  localparam int AW = $clog2(ACT_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          hsync_n_o,
  output logic          vsync_n_o,
  output logic          vsync_start_o,
  output logic          field_o,
  output logic          de_o,
  output logic [HW-1:0] pixel_o,
  output logic [LW-1:0] line_o,
  output logic [AW-1:0] act_line_o
);

  logic [HW-1:0] h;
  logic          h_wrap;
  logic [LW-1:0] ln;
  raster_flags_t flags_d, flags_q;
  logic [AW-1:0] act_d, act_q;
  logic [HW-1:0] px_q;
  logic [LW-1:0] ln_q;

  raster_h_counter #(.H_TOTAL(H_TOTAL)) u_hcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .h_o   (h),
    .wrap_o(h_wrap)
  );

  raster_v_counter #(.FRAME_LINES(FRAME_LINES)) u_vcnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (h_wrap),
    .ln_o  (ln)
  );

  raster_decode #(
    .H_TOTAL     (H_TOTAL),
    .H_ACTIVE    (H_ACTIVE),
    .H_FRONT     (H_FRONT),
    .H_SYNC      (H_SYNC),
    .V_SYNC_LINES(V_SYNC_LINES),
    .FRAME_LINES (FRAME_LINES),
    .ACT_LINES   (ACT_LINES)
  ) u_dec (
    .h_i       (h),
    .ln_i      (ln),
    .flags_o   (flags_d),
    .act_line_o(act_d)
  );

  // registered outputs, one clock behind the counters
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= FLAGS_IDLE;
      act_q   <= '0;
      px_q    <= '0;
      ln_q    <= '0;
    end else begin
      flags_q <= flags_d;
      act_q   <= act_d;
      px_q    <= h;
      ln_q    <= ln;
    end
  end

  assign hsync_n_o     = flags_q.hsync_n;
  assign vsync_n_o     = flags_q.vsync_n;
  assign vsync_start_o = flags_q.vsync_start;
  assign field_o       = flags_q.field;
  assign de_o          = flags_q.de;
  assign pixel_o       = px_q;
  assign line_o        = ln_q;
  assign act_line_o    = act_q;

endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
  parameter int H_TOTAL      = 910,
  parameter int H_ACTIVE     = 640,
  parameter int H_FRONT      = 16,
  parameter int H_SYNC       = 68,
  parameter int V_SYNC_LINES = 3,
  parameter int FRAME_LINES  = 525,
  parameter int ACT_LINES    = 192,
  localparam int HW = $clog2(H_TOTAL + 1),
  localparam int LW = $clog2(FRAME_LINES + 1),
  localparam int AW = $clog2(ACT_LINES)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_n_o,
  input logic          vsync_n_o,
  input logic          vsync_start_o,
  input logic          field_o,
  input logic          de_o,
  input logic [HW-1:0] pixel_o,
  input logic [LW-1:0] line_o,
  input logic [AW-1:0] act_line_o
);

  a_r1_pixel_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pixel_o != '0) |-> (int'(pixel_o) == int'($past(pixel_o)) + 1));

  a_r1_line_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(line_o) < FRAME_LINES);

  a_r1_line_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o != $past(line_o)) |-> (pixel_o == '0));

  a_r2_hsync_place: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_n_o) |-> (int'(pixel_o) == H_ACTIVE + H_FRONT));

  a_r5_vst_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_start_o |-> (!vsync_n_o && $past(vsync_n_o)));

  a_r5_vst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_start_o |=> !vsync_start_o);

  a_r6_field_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (field_o != $past(field_o)) |-> vsync_start_o);

  a_r7_de_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> ((int'(pixel_o) < H_ACTIVE) && vsync_n_o));

  a_r8_act_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(act_line_o) < ACT_LINES);

endmodule

bind raster_timing_gen raster_timing_gen_chk #(
  .H_TOTAL     (H_TOTAL),
  .H_ACTIVE    (H_ACTIVE),
  .H_FRONT     (H_FRONT),
  .H_SYNC      (H_SYNC),
  .V_SYNC_LINES(V_SYNC_LINES),
  .FRAME_LINES (FRAME_LINES),
  .ACT_LINES   (ACT_LINES)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hsync_n_o    (hsync_n_o),
  .vsync_n_o    (vsync_n_o),
  .vsync_start_o(vsync_start_o),
  .field_o      (field_o),
  .de_o         (de_o),
  .pixel_o      (pixel_o),
  .line_o       (line_o),
  .act_line_o   (act_line_o)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;

  localparam int HT  = 16;
  localparam int HA  = 10;
  localparam int HF  = 2;
  localparam int HS  = 2;
  localparam int VSL = 3;
  localparam int FL  = 525;
  localparam int AL  = 192;
  localparam int HALF = HT / 2;
  localparam int FW   = (FL - 1) / 2;
  localparam int A0   = (FW - AL) / 2;
  localparam int A1   = FW + 1 + A0;
  localparam int HSB  = HA + HF;
  localparam int FIELD_CLK = FL * HT / 2;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic       hsync_n_o, vsync_n_o, vsync_start_o, field_o, de_o;
  logic [4:0] pixel_o;
  logic [9:0] line_o;
  logic [7:0] act_line_o;

  raster_timing_gen #(
    .H_TOTAL(HT), .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS),
    .V_SYNC_LINES(VSL), .FRAME_LINES(FL), .ACT_LINES(AL)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o),
    .vsync_start_o(vsync_start_o), .field_o(field_o), .de_o(de_o),
    .pixel_o(pixel_o), .line_o(line_o), .act_line_o(act_line_o)
  );

  int checks = 0;
  int errors = 0;
  int t = 0;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) t <= 0; else t <= t + 1;

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected outputs for counter state s (s clocks after reset release)
  task automatic model(input int s, output int px, output int ln, output int hs_n,
                       output int vs_n, output int vst, output int fld,
                       output int de, output int al);
    int hl, hlf, base, act;
    px   = s % HT;
    ln   = (s / HT) % FL;
    hl   = 2 * ln + ((px >= HALF) ? 1 : 0);
    fld  = (hl >= FL) ? 1 : 0;
    hlf  = fld ? hl - FL : hl;
    vs_n = (hlf < 2 * VSL) ? 0 : 1;
    vst  = ((px == 0 && ln == 0) || (px == HALF && ln == FW)) ? 1 : 0;
    hs_n = (px >= HSB && px < HSB + HS) ? 0 : 1;
    base = fld ? A1 : A0;
    act  = (ln >= base && ln < base + AL) ? 1 : 0;
    de   = (act != 0 && px < HA) ? 1 : 0;
    al   = act ? ln - base : 0;
  endtask

  task automatic check_idle(input string tag);
    chk_eq({tag, " R9 hsync_n"}, int'(hsync_n_o), 1);
    chk_eq({tag, " R9 vsync_n"}, int'(vsync_n_o), 1);
    chk_eq({tag, " R9 vsync_start"}, int'(vsync_start_o), 0);
    chk_eq({tag, " R9 field"}, int'(field_o), 0);
    chk_eq({tag, " R9 de"}, int'(de_o), 0);
    chk_eq({tag, " R9 pixel"}, int'(pixel_o), 0);
    chk_eq({tag, " R9 line"}, int'(line_o), 0);
    chk_eq({tag, " R9 act_line"}, int'(act_line_o), 0);
  endtask

  // monitor state
  int  prev_vst, prev_de, prev_vs, prev_hs;
  int  vlow, hlow, seen, last_t, last_field;
  int  de_cnt, de_lines, first_line, first_act, last_act;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      prev_vst = 0; prev_de = 0; prev_vs = 1; prev_hs = 1;
      vlow = 0; hlow = 0; seen = 0; last_t = 0; last_field = 0;
      de_cnt = 0; de_lines = 0; first_line = -1; first_act = -1; last_act = -1;
    end else if (t >= 1) begin
      if ($urandom % 4 == 0) begin
        int px, ln, hs_n, vs_n, vst, fld, de, al;
        model(t - 1, px, ln, hs_n, vs_n, vst, fld, de, al);
        chk_eq("R1 pixel", int'(pixel_o), px);
        chk_eq("R1 line", int'(line_o), ln);
        chk_eq("R2 hsync_n", int'(hsync_n_o), hs_n);
        chk_eq("R4 vsync_n", int'(vsync_n_o), vs_n);
        chk_eq("R5 vsync_start", int'(vsync_start_o), vst);
        chk_eq("R6 field", int'(field_o), fld);
        chk_eq("R7 de", int'(de_o), de);
        chk_eq("R8 act_line", int'(act_line_o), al);
      end
      if (vsync_start_o) begin
        chk_eq("R5 vsync_start lone pulse", prev_vst, 0);
        chk_eq("R3 field start pixel", int'(pixel_o), field_o ? HALF : 0);
        chk_eq("R3 field start line", int'(line_o), field_o ? FW : 0);
        if (seen != 0) begin
          chk_eq("R3 clocks per field", t - last_t, FIELD_CLK);
          chk_eq("R6 field alternates", int'(field_o), 1 - last_field);
          chk_eq("R7 enabled clocks per field", de_cnt, AL * HA);
          chk_eq("R7 active lines per field", de_lines, AL);
          chk_eq("R7 first active line", first_line, last_field ? A1 : A0);
          chk_eq("R8 first act_line", first_act, 0);
          chk_eq("R8 last act_line", last_act, AL - 1);
        end
        seen = 1; last_t = t; last_field = int'(field_o);
        de_cnt = 0; de_lines = 0; first_line = -1; first_act = -1; last_act = -1;
      end
      if (de_o) begin
        de_cnt++;
        if (prev_de == 0) begin
          de_lines++;
          if (first_line < 0) begin
            first_line = int'(line_o);
            first_act  = int'(act_line_o);
          end
        end
        last_act = int'(act_line_o);
      end
      if (!vsync_n_o) vlow++;
      else if (prev_vs == 0) begin
        chk_eq("R4 vsync width", vlow, VSL * HT);
        vlow = 0;
      end
      if (!hsync_n_o) begin
        if (prev_hs != 0) chk_eq("R2 hsync start pixel", int'(pixel_o), HSB);
        hlow++;
      end else if (prev_hs == 0) begin
        chk_eq("R2 hsync width", hlow, HS);
        hlow = 0;
      end
      prev_vst = int'(vsync_start_o);
      prev_de  = int'(de_o);
      prev_vs  = int'(vsync_n_o);
      prev_hs  = int'(hsync_n_o);
    end
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_i);
    check_idle("initial");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_eq("R9 first vsync_start after release", int'(vsync_start_o), 1);
    chk_eq("R9 first line after release", int'(line_o), 0);
    repeat (3 * FL * HT + int'($urandom % 1000)) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check_idle("midrun");
    repeat (2 + int'($urandom % 5)) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2 * FL * HT + 50) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule